// File: doc/BRIEF.md
# Work Tag State Tracker

This block follows the scheduling tag type held by each of a small set of processing cores and checks every change that is asked of it. Each core has its own two-bit tag type, with ordered = 0, atomic = 1, null = 2 and null-null = 3. A core leaves reset in null-null and returns there on a deschedule. The way out of null-null is a new-work request, which carries the type of the new work. A null-switch load is the other way out, and it moves the core to null. Once a core holds work, tag-switch requests move it among ordered, atomic and null. A request that breaks the rules gives a one-cycle error pulse and changes nothing.

The atomic type means exclusive ownership. When a core switches to atomic, its busy flag rises and stays up until a shared arbiter grants ownership. At most one core owns at any time. When several cores wait, the lowest core index wins, and a grant is only issued while no core owns. Ownership ends when the owner switches to ordered or null, or when it is descheduled. A parameter can remove the arbiter. In that variant atomic is taken at once and the block does not model exclusivity.

Top module: `tag_state_tracker`

## Requirements
- R1: After reset every core's `cur_type` is 3 (null-null). `err_pulse`, `busy` and `atom_own` are low. Tag codes are ordered = 0, atomic = 1, null = 2, null-null = 3.
- R2: A tag-switch request from null (2) with target null (2) is illegal.
- R3: A tag-switch request with target null-null (3) is illegal, whatever the current type.
- R4: A tag-switch request made while the core is in null-null (3) is illegal.
- R5: A legal tag switch sets `cur_type` to the target on the clock edge that samples the request.
- R6: An illegal request leaves `cur_type`, `busy` and `atom_own` unchanged. It drives `err_pulse` high for exactly the one cycle after the edge that samples it.
- R7: A deschedule is legal from any state. On the next cycle it gives `cur_type` = 3 and clears `busy` and `atom_own`, even when a grant arrives in the same cycle.
- R8: A new-work request is legal only in null-null, and only with a target (taken from `sw_type`) other than 3. It sets `cur_type` to that target. Any other new-work request is illegal.
- R9: A null-switch load moves null-null (3) to null (2). From any other state it is illegal.
- R10: An accepted move to atomic (1) by a core that does not own sets `cur_type` = 1 and raises `busy` until a grant. A switch, new-work or null-switch load request while `busy` is high is illegal.
- R11: At most one core has `atom_own` high. Ownership is released on a legal move to ordered or null, or on a deschedule.
- R12: A grant goes only when no core owns, to the lowest-index busy core. It gives `atom_own` = 1 and `busy` = 0 one cycle later. An atomic-to-atomic switch by the owner keeps ownership and does not raise `busy`.
- R13: When a core raises several strobes in one cycle, only one acts, in the order deschedule, then new-work, then null-switch load, then tag switch. The others are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | NCORES | Tag-switch request, one bit per core |
| sw_type | input | 2*NCORES | Target type per core (bits 2i+1:2i), used by switch and new-work |
| work_req | input | NCORES | New-work request per core |
| desched_req | input | NCORES | Deschedule strobe per core |
| nload_req | input | NCORES | Null-switch load strobe per core |
| cur_type | output | 2*NCORES | Current tag type per core (bits 2i+1:2i) |
| err_pulse | output | NCORES | One-cycle illegal-request pulse per core |
| busy | output | NCORES | Atomic switch waiting for a grant |
| atom_own | output | NCORES | Core holds exclusive atomic ownership |

## Verification
The bench goes after the forbidden moves: null to null, any switch to null-null, and any switch out of null-null. A design that filtered too little would let the core leave null-null without new work. One that filtered too much would reject a legal null-to-ordered move. It drives two cores to atomic in the same cycle. An arbiter with the wrong priority, or one that grants while another core still owns, would then show two owners or the wrong winner. Simultaneous strobes and a deschedule of a core that owns or waits are also covered. A wrong priority order or a leaked ownership bit would show up as a core stuck in busy or a later grant that never comes.

// File: rtl/tag_pkg.sv
package tag_pkg;

  typedef enum logic [1:0] {
    TAG_ORD  = 2'd0,
    TAG_ATOM = 2'd1,
    TAG_NUL  = 2'd2,
    TAG_NN   = 2'd3
  } tag_e;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_DESCHED = 3'd1,
    OP_WORK    = 3'd2,
    OP_NLOAD   = 3'd3,
    OP_SWITCH  = 3'd4
  } op_e;

  // Strobe priority: deschedule, new work, null load, switch.
  function automatic op_e pick_op(input logic ds, input logic wk,
                                  input logic nl, input logic sw);
    if (ds)      return OP_DESCHED;
    else if (wk) return OP_WORK;
    else if (nl) return OP_NLOAD;
    else if (sw) return OP_SWITCH;
    else         return OP_IDLE;
  endfunction

  // Legality of the chosen operation from the current state.
  function automatic logic step_legal(input op_e op, input tag_e cur,
                                      input tag_e tgt, input logic pend);
    case (op)
      OP_DESCHED: return 1'b1;
      OP_WORK:    return !pend && (cur == TAG_NN) && (tgt != TAG_NN);
      OP_NLOAD:   return !pend && (cur == TAG_NN);
      OP_SWITCH:  return !pend && (cur != TAG_NN) && (tgt != TAG_NN) &&
                         !((cur == TAG_NUL) && (tgt == TAG_NUL));
      default:    return 1'b1;
    endcase
  endfunction

  function automatic logic is_request(input op_e op);
    return (op == OP_WORK) || (op == OP_NLOAD) || (op == OP_SWITCH);
  endfunction

endpackage

// File: rtl/tag_core_fsm.sv
module tag_core_fsm
  import tag_pkg::*;
#(
  parameter bit ARB_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic desched_i,
  input  logic work_i,
  input  logic nload_i,
  input  logic sw_i,
  input  tag_e tgt_i,
  input  logic grant_i,
  output tag_e cur_o,
  output logic err_o,
  output logic pend_o,
  output logic own_o
);

  tag_e cur_q;
  logic err_q, pend_q, own_q;

  op_e  op_w;
  logic legal_w;
  logic take_w;

  assign op_w    = pick_op(desched_i, work_i, nload_i, sw_i);
  assign legal_w = step_legal(op_w, cur_q, tgt_i, pend_q);
  assign take_w  = grant_i && (op_w != OP_DESCHED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= TAG_NN;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      own_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (op_w)
        OP_DESCHED: begin
          cur_q  <= TAG_NN;
          pend_q <= 1'b0;
          own_q  <= 1'b0;
        end
        OP_NLOAD: begin
          if (legal_w) cur_q <= TAG_NUL;
          else         err_q <= 1'b1;
        end
        OP_WORK, OP_SWITCH: begin
          if (legal_w) begin
            cur_q <= tgt_i;
            if (tgt_i == TAG_ATOM) begin
              if (!own_q) begin
                if (ARB_EN) pend_q <= 1'b1;
                else        own_q  <= 1'b1;
              end
            end else begin
              own_q <= 1'b0;
            end
          end else begin
            err_q <= 1'b1;
          end
        end
        default: ;
      endcase
      if (take_w) begin
        own_q  <= 1'b1;
        pend_q <= 1'b0;
      end
    end
  end

  assign cur_o  = cur_q;
  assign err_o  = err_q;
  assign pend_o = pend_q;
  assign own_o  = own_q;

endmodule

// File: rtl/tag_atomic_arb.sv
module tag_atomic_arb #(
  parameter int NCORES = 3
) (
  input  logic [NCORES-1:0] pend_i,
  input  logic [NCORES-1:0] own_i,
  output logic [NCORES-1:0] grant_o
);

  logic owned_w;
  assign owned_w = |own_i;

  always_comb begin
    logic hit;
    hit     = 1'b0;
    grant_o = '0;
    if (!owned_w) begin
      for (int i = 0; i < NCORES; i++) begin
        if (pend_i[i] && !hit) begin
          grant_o[i] = 1'b1;
          hit        = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tag_state_tracker.sv
module tag_state_tracker
  import tag_pkg::*;
#(
  parameter int NCORES = 3,
  parameter bit ARB_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCORES-1:0]   sw_req,
  input  logic [2*NCORES-1:0] sw_type,
  input  logic [NCORES-1:0]   work_req,
  input  logic [NCORES-1:0]   desched_req,
  input  logic [NCORES-1:0]   nload_req,
  output logic [2*NCORES-1:0] cur_type,
  output logic [NCORES-1:0]   err_pulse,
  output logic [NCORES-1:0]   busy,
  output logic [NCORES-1:0]   atom_own
);

  localparam int TW = 2;

  logic [NCORES-1:0] arb_grant;
  tag_e              cur_w [NCORES];

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    tag_core_fsm #(.ARB_EN(ARB_EN)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .desched_i(desched_req[i]),
      .work_i   (work_req[i]),
      .nload_i  (nload_req[i]),
      .sw_i     (sw_req[i]),
      .tgt_i    (tag_e'(sw_type[TW*i +: TW])),
      .grant_i  (arb_grant[i]),
      .cur_o    (cur_w[i]),
      .err_o    (err_pulse[i]),
      .pend_o   (busy[i]),
      .own_o    (atom_own[i])
    );
    assign cur_type[TW*i +: TW] = cur_w[i];
  end

  if (ARB_EN) begin : g_arb
    tag_atomic_arb #(.NCORES(NCORES)) u_arb (
      .pend_i (busy),
      .own_i  (atom_own),
      .grant_o(arb_grant)
    );
  end else begin : g_noarb
    assign arb_grant = '0;
  end

endmodule

// File: rtl/tag_state_tracker_chk.sv
module tag_state_tracker_chk #(
  parameter int NCORES = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCORES-1:0]   sw_req,
  input logic [NCORES-1:0]   work_req,
  input logic [NCORES-1:0]   desched_req,
  input logic [NCORES-1:0]   nload_req,
  input logic [2*NCORES-1:0] cur_type,
  input logic [NCORES-1:0]   err_pulse,
  input logic [NCORES-1:0]   busy,
  input logic [NCORES-1:0]   atom_own,
  input logic [NCORES-1:0]   arb_grant
);

  // R11
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(atom_own));

  // R12
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_grant) && ((arb_grant == '0) || (atom_own == '0)));

  for (genvar i = 0; i < NCORES; i++) begin : g_c
    // R4
    from_nn_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_type[2*i +: 2] == 2'd3 && sw_req[i] && !desched_req[i] &&
       !work_req[i] && !nload_req[i]) |=> err_pulse[i]);

    // R6
    err_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse[i] |-> (cur_type[2*i +: 2] == $past(cur_type[2*i +: 2])));

    // R7
    desched_to_nn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desched_req[i] |=> (cur_type[2*i +: 2] == 2'd3 && !busy[i] &&
                          !atom_own[i] && !err_pulse[i]));

    // R10
    busy_is_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] |-> (cur_type[2*i +: 2] == 2'd1 && !atom_own[i]));

    // R12
    grant_to_waiter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arb_grant[i] |-> busy[i]);

    // R12
    grant_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_grant[i] && !desched_req[i]) |=> (atom_own[i] && !busy[i]));

    // R12
    lower_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[i] && ((busy & ((NCORES)'(1) << i) - (NCORES)'(1)) != '0))
      |-> !arb_grant[i]);

    // R9
    nn_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_type[2*i +: 2] == 2'd3 && !work_req[i] && !nload_req[i])
      |=> cur_type[2*i +: 2] == 2'd3);
  end

endmodule

bind tag_state_tracker tag_state_tracker_chk #(.NCORES(NCORES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_req     (sw_req),
  .work_req   (work_req),
  .desched_req(desched_req),
  .nload_req  (nload_req),
  .cur_type   (cur_type),
  .err_pulse  (err_pulse),
  .busy       (busy),
  .atom_own   (atom_own),
  .arb_grant  (arb_grant)
);

// File: tb/tag_state_tracker_tb.sv
`timescale 1ns/1ps
module tag_state_tracker_tb_top;

  localparam int N = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   sw_req = '0;
  logic [2*N-1:0] sw_type = '0;
  logic [N-1:0]   work_req = '0;
  logic [N-1:0]   desched_req = '0;
  logic [N-1:0]   nload_req = '0;
  logic [2*N-1:0] cur_type;
  logic [N-1:0]   err_pulse;
  logic [N-1:0]   busy;
  logic [N-1:0]   atom_own;

  int total = 0;
  int bad = 0;
  string lbl = "R1";

  int m_cur [N];
  int m_err [N];
  int m_pend[N];
  int m_own [N];

  always #5 clk = ~clk;

  tag_state_tracker #(.NCORES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_type(sw_type),
    .work_req(work_req), .desched_req(desched_req), .nload_req(nload_req),
    .cur_type(cur_type), .err_pulse(err_pulse), .busy(busy), .atom_own(atom_own)
  );

  // Behavioural reference: rules written as plain integer updates.
  always @(posedge clk) begin : mdl
    int winner;
    int anyown;
    int t;
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin
        m_cur[c] = 3; m_err[c] = 0; m_pend[c] = 0; m_own[c] = 0;
      end
    end else begin
      anyown = 0;
      winner = -1;
      for (int c = 0; c < N; c++) if (m_own[c] != 0) anyown = 1;
      if (anyown == 0)
        for (int c = N - 1; c >= 0; c--) if (m_pend[c] != 0) winner = c;
      for (int c = 0; c < N; c++) begin
        t = int'(sw_type[2*c +: 2]);
        m_err[c] = 0;
        if (desched_req[c]) begin
          m_cur[c] = 3; m_pend[c] = 0; m_own[c] = 0;
        end else begin
          if (work_req[c]) begin
            if (m_cur[c] == 3 && t != 3 && m_pend[c] == 0) begin
              m_cur[c] = t;
              if (t == 1) begin if (m_own[c] == 0) m_pend[c] = 1; end
              else m_own[c] = 0;
            end else m_err[c] = 1;
          end else if (nload_req[c]) begin
            if (m_cur[c] == 3) m_cur[c] = 2; else m_err[c] = 1;
          end else if (sw_req[c]) begin
            if (m_pend[c] == 0 && m_cur[c] != 3 && t != 3 &&
                !(m_cur[c] == 2 && t == 2)) begin
              m_cur[c] = t;
              if (t == 1) begin if (m_own[c] == 0) m_pend[c] = 1; end
              else m_own[c] = 0;
            end else m_err[c] = 1;
          end
          if (winner == c) begin m_own[c] = 1; m_pend[c] = 0; end
        end
      end
    end
  end

  task automatic chk(input string what, input int c, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s core%0d %s got=%0d exp=%0d", lbl, c, what, got, exp);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < N; c++) begin
      chk("cur_type", c, int'(cur_type[2*c +: 2]), m_cur[c]);
      chk("err_pulse", c, int'(err_pulse[c]), m_err[c]);
      chk("busy", c, int'(busy[c]), m_pend[c]);
      chk("atom_own", c, int'(atom_own[c]), m_own[c]);
    end
  endtask

  task automatic clear_in();
    sw_req = '0; work_req = '0; desched_req = '0; nload_req = '0; sw_type = '0;
  endtask

  // kind: 0 switch, 1 new work, 2 deschedule, 3 null load
  task automatic put(input int c, input int kind, input int t);
    sw_type[2*c +: 2] = 2'(t);
    case (kind)
      0: sw_req[c] = 1'b1;
      1: work_req[c] = 1'b1;
      2: desched_req[c] = 1'b1;
      default: nload_req[c] = 1'b1;
    endcase
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    clear_in();
  endtask

  task automatic expect_core(input int c, input int cur, input int e, input int b, input int o);
    chk("dir_cur", c, int'(cur_type[2*c +: 2]), cur);
    chk("dir_err", c, int'(err_pulse[c]), e);
    chk("dir_busy", c, int'(busy[c]), b);
    chk("dir_own", c, int'(atom_own[c]), o);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lbl = "R1"; compare_all();
    for (int c = 0; c < N; c++) expect_core(c, 3, 0, 0, 0);

    lbl = "R4"; put(0, 0, 0); tick(); expect_core(0, 3, 1, 0, 0);
    lbl = "R6"; tick(); expect_core(0, 3, 0, 0, 0);
    lbl = "R9"; put(0, 3, 0); tick(); expect_core(0, 2, 0, 0, 0);
    lbl = "R9"; put(0, 3, 0); tick(); expect_core(0, 2, 1, 0, 0);
    lbl = "R2"; put(0, 0, 2); tick(); expect_core(0, 2, 1, 0, 0);
    lbl = "R3"; put(0, 0, 3); tick(); expect_core(0, 2, 1, 0, 0);
    lbl = "R5"; put(0, 0, 0); tick(); expect_core(0, 0, 0, 0, 0);
    put(0, 0, 2); tick(); expect_core(0, 2, 0, 0, 0);
    put(0, 0, 0); tick(); expect_core(0, 0, 0, 0, 0);

    lbl = "R8"; put(1, 1, 0); tick(); expect_core(1, 0, 0, 0, 0);
    put(1, 1, 2); tick(); expect_core(1, 0, 1, 0, 0);
    put(2, 1, 3); tick(); expect_core(2, 3, 1, 0, 0);

    lbl = "R10"; put(0, 0, 1); put(1, 0, 1); tick();
    expect_core(0, 1, 0, 1, 0); expect_core(1, 1, 0, 1, 0);
    lbl = "R12"; put(1, 0, 0); tick();
    expect_core(0, 1, 0, 0, 1); expect_core(1, 1, 1, 1, 0);
    put(0, 0, 1); tick(); expect_core(0, 1, 0, 0, 1); expect_core(1, 1, 0, 1, 0);
    lbl = "R11"; put(0, 0, 0); tick(); expect_core(0, 0, 0, 0, 0);
    expect_core(1, 1, 0, 1, 0);
    tick(); expect_core(1, 1, 0, 0, 1);
    lbl = "R7"; put(1, 2, 0); tick(); expect_core(1, 3, 0, 0, 0);
    put(2, 2, 0); tick(); expect_core(2, 3, 0, 0, 0);

    lbl = "R13"; put(2, 2, 0); put(2, 1, 0); tick(); expect_core(2, 3, 0, 0, 0);
    put(2, 1, 0); put(2, 3, 0); tick(); expect_core(2, 0, 0, 0, 0);
    put(2, 3, 0); put(2, 0, 2); tick(); expect_core(2, 0, 1, 0, 0);

    lbl = "R11";
    for (int k = 0; k < 3000; k++) begin
      for (int c = 0; c < N; c++) begin
        if ($urandom_range(0, 9) < 3) put(c, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
        if ($urandom_range(0, 19) == 0) put(c, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      end
      tick();
    end
    repeat (4) tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule